// File: doc/BRIEF.md
# Descriptor DMA Channel Register Front End

This block sits between a 32-bit register bus and the descriptor engines of a multi-channel DMA controller. Every channel gets its own 8 KiB address window. Each window holds the channel's pointer registers, its configuration, its interrupt mask and acknowledge registers, a command register and a stream-command register. The block keeps every channel in one of three one-hot states (reset, stopped, running). It builds the status word from that live state rather than from a stored register.

Writes that ask for descriptor work become engine commands on a valid/ready port. A single shared sequencer issues them. For each load, the engine returns the decoded descriptor fields on a response strobe. The sequencer then updates the channel's pointers and end-of-list flags, and issues a start when the request calls for one. A command write is a continue. It restarts a channel that ran off the end of its list, but only after software has cleared the end-of-list flag in the parked descriptor. While a sequence is in flight, a second write that needs the sequencer is held off: bus_ack stays low until the sequencer is idle.

Top module: `dma_ctl_front`

## Requirements
- R1: The channel index is bus_addr[15:13] and the register index is bus_addr[7:2]. Word registers are at byte offsets 0x58 (descriptor pointer), 0x5C (buffer pointer), 0x60 (group pointer) and 0x7C (context pointer), and each reads back what was written. Any access to a channel index of NUM_CH or more returns bus_err with zero data.
- R2: Reading offset 0x88 returns the channel state in bits [2:0] (reset 1, stopped 2, running 4), the channel end-of-list flag in bit 5, a constant 1 in bit 8 and the sticky error flag in bit 9. After reset this word is 0x101.
- R3: A write to the configuration register at 0x84 stores bits [1:0]. Bit 1 set moves the channel to stopped, bit 0 clear moves it to reset, and the reset rule wins if both apply.
- R4: A write to the stream-command register at 0x9C with bit 6 or bit 8 set issues a data-descriptor load (op 0) at the descriptor pointer. If bit 5 is also set and a client is attached, a start (op 2) follows and the channel becomes running with its end-of-list flag clear. Bit 9 then issues a context load (op 1) at the context pointer. Commands always follow this order.
- R5: A context-load response replaces the descriptor pointer with rsp_link and the buffer pointer with rsp_buf.
- R6: The raw interrupt at 0x94 ORs in evt_irq. Writing the acknowledge register at 0x90 clears the matching raw bits, and 0x90 reads as zero. The masked value at 0x98 is raw AND the mask at 0x8C. irq[ch] is high in the cycle after a mask or acknowledge write exactly when that masked value is nonzero.
- R7: A write to the command register at 0x80 issues nothing unless all of these hold: config bit 0 is set, a client is attached, config bit 1 is clear, the channel is running, and the current descriptor's end-of-list flag is set.
- R8: An accepted continue reloads the descriptor (op 0). If the reloaded descriptor's end-of-list flag is clear and the channel end-of-list flag is set, the pointer advances to rsp_link, that descriptor is loaded (op 0), the buffer pointer takes its rsp_buf, and a start (op 2) restarts the channel with its end-of-list flag clear. Otherwise only the buffer pointer takes rsp_buf.
- R9: Command writes with bits above bit 0 set, and stream-command writes with bits above bit 9 set, are stored and read back in full, and they set the sticky status bit 9.
- R10: Any access with bus_size other than 2 (word) is acknowledged with bus_err and zero data and changes no register.
- R11: An engine event with evt_eol set makes status bit 5 read 1 and sets the current descriptor's end-of-list flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access completes at this clock edge |
| bus_err | output | 1 | Error response for the current access |
| client_present | input | NUM_CH | A client is attached to the channel |
| evt_valid | input | 1 | Engine event strobe |
| evt_ch | input | CH_W | Channel of the engine event |
| evt_irq | input | IRQ_W | Raw interrupt bits to set |
| evt_eol | input | 1 | The channel reached an end-of-list descriptor |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 load data descriptor, 1 load context, 2 start |
| cmd_ch | output | CH_W | Channel of the command |
| cmd_addr | output | 32 | Descriptor address for the command |
| rsp_valid | input | 1 | Load response strobe |
| rsp_eol | input | 1 | End-of-list flag of the loaded descriptor |
| rsp_link | input | 32 | Next-descriptor link or saved descriptor pointer |
| rsp_buf | input | 32 | Buffer pointer from the loaded descriptor |
| irq | output | NUM_CH | Per-channel interrupt line |

## Verification
The bench builds the block with NUM_CH = 3 and a 16-bit address. The index field then has room for channel 3, which is out of range, so the error path for a missing channel becomes reachable. Three channels are enough for one to run the continue path, one to take interrupts and context loads, and one with no client attached, so that burst starts can be checked for being withheld. The engine model in the bench answers every load two cycles after accepting it. This lets the multi-step continue sequence finish, and its command order and addresses can be scored against the queue of expected commands.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  localparam int WIN_SHIFT = 13;

  typedef enum logic [2:0] {
    ST_RESET   = 3'b001,
    ST_STOPPED = 3'b010,
    ST_RUNNING = 3'b100
  } chan_state_e;

  typedef enum logic [1:0] {
    OP_LOAD_DATA = 2'd0,
    OP_LOAD_CTX  = 2'd1,
    OP_START     = 2'd2
  } eng_op_e;

  localparam logic [5:0] RI_DATA_PTR = 6'h16;
  localparam logic [5:0] RI_BUF_PTR  = 6'h17;
  localparam logic [5:0] RI_GROUP    = 6'h18;
  localparam logic [5:0] RI_CTX_PTR  = 6'h1F;
  localparam logic [5:0] RI_CMD      = 6'h20;
  localparam logic [5:0] RI_CFG      = 6'h21;
  localparam logic [5:0] RI_STATUS   = 6'h22;
  localparam logic [5:0] RI_MASK     = 6'h23;
  localparam logic [5:0] RI_ACK      = 6'h24;
  localparam logic [5:0] RI_RAW      = 6'h25;
  localparam logic [5:0] RI_MASKED   = 6'h26;
  localparam logic [5:0] RI_STREAM   = 6'h27;

  localparam logic [9:0] SC_LOAD_DATA = 10'h140;
  localparam logic [9:0] SC_BURST     = 10'h020;
  localparam logic [9:0] SC_LOAD_CTX  = 10'h200;
  localparam logic [1:0] SIZE_WORD    = 2'd2;

  typedef struct packed {
    logic        desc_eol_we;
    logic        desc_eol;
    logic        data_we;
    logic [31:0] data_ptr;
    logic        buf_we;
    logic [31:0] buf_ptr;
    logic        start;
  } seq_upd_t;

  function automatic logic [31:0] status_word(chan_state_e st, logic eol, logic err);
    logic [31:0] w;
    w      = '0;
    w[2:0] = st;
    w[5]   = eol;
    w[8]   = 1'b1;
    w[9]   = err;
    return w;
  endfunction

  function automatic logic stream_needs_engine(logic [31:0] v);
    return |(v[9:0] & (SC_LOAD_DATA | SC_LOAD_CTX));
  endfunction

  function automatic logic stray_bits(logic [31:0] v, int unsigned legal_w);
    return (v >> legal_w) != 32'd0;
  endfunction

endpackage

// File: rtl/dcf_decode.sv
module dcf_decode #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  localparam int CHF_W = ADDR_W - dcf_pkg::WIN_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [CHF_W-1:0]  ch_idx,
  output logic [5:0]        reg_idx,
  output logic              word_ok,
  output logic              ch_ok
);
  import dcf_pkg::*;

  logic unused_alias;

  assign ch_idx       = addr[ADDR_W-1:WIN_SHIFT];
  assign reg_idx      = addr[7:2];
  assign word_ok      = (size == SIZE_WORD);
  assign ch_ok        = 32'(ch_idx) < 32'(NUM_CH);
  assign unused_alias = ^{addr[WIN_SHIFT-1:8], addr[1:0]};

endmodule

// File: rtl/dcf_chan.sv
module dcf_chan #(
  parameter int IRQ_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [5:0]           reg_idx,
  input  logic [31:0]          wdata,
  input  logic                 evt_hit,
  input  logic [IRQ_W-1:0]     evt_irq,
  input  logic                 evt_eol,
  input  logic                 upd_hit,
  input  dcf_pkg::seq_upd_t    upd,
  output logic [31:0]          rd_data,
  output logic [31:0]          data_ptr,
  output logic [31:0]          ctx_ptr,
  output dcf_pkg::chan_state_e state,
  output logic                 ch_eol,
  output logic                 desc_eol,
  output logic                 cfg_en,
  output logic                 cfg_stop,
  output logic                 irq
);
  import dcf_pkg::*;

  logic [31:0]      data_q, buf_q, group_q, ctx_q, cmd_q, strm_q;
  logic [1:0]       cfg_q;
  logic [IRQ_W-1:0] mask_q, raw_q;
  chan_state_e      state_q;
  logic             ch_eol_q, desc_eol_q, err_q;

  logic cfg_wr, ack_wr;
  assign cfg_wr = wr_en && (reg_idx == RI_CFG);
  assign ack_wr = wr_en && (reg_idx == RI_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      buf_q      <= '0;
      group_q    <= '0;
      ctx_q      <= '0;
      cmd_q      <= '0;
      strm_q     <= '0;
      cfg_q      <= '0;
      mask_q     <= '0;
      raw_q      <= '0;
      state_q    <= ST_RESET;
      ch_eol_q   <= 1'b0;
      desc_eol_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      // sequencer start, then engine events, then bus writes
      if (upd_hit && upd.start) begin
        state_q  <= ST_RUNNING;
        ch_eol_q <= 1'b0;
      end
      if (evt_hit && evt_eol) begin
        ch_eol_q   <= 1'b1;
        desc_eol_q <= 1'b1;
      end
      raw_q <= (raw_q & ~(ack_wr ? wdata[IRQ_W-1:0] : '0)) | (evt_hit ? evt_irq : '0);
      if (wr_en) begin
        unique case (reg_idx)
          RI_DATA_PTR: data_q  <= wdata;
          RI_BUF_PTR:  buf_q   <= wdata;
          RI_GROUP:    group_q <= wdata;
          RI_CTX_PTR:  ctx_q   <= wdata;
          RI_MASK:     mask_q  <= wdata[IRQ_W-1:0];
          RI_CMD: begin
            cmd_q <= wdata;
            if (stray_bits(wdata, 1)) err_q <= 1'b1;
          end
          RI_STREAM: begin
            strm_q <= wdata;
            if (stray_bits(wdata, 10)) err_q <= 1'b1;
          end
          RI_CFG: begin
            cfg_q <= wdata[1:0];
            if (wdata[1])  state_q <= ST_STOPPED;
            if (!wdata[0]) state_q <= ST_RESET;
          end
          default: ;
        endcase
      end
      // engine results take priority over software pointer writes
      if (upd_hit && upd.desc_eol_we) desc_eol_q <= upd.desc_eol;
      if (upd_hit && upd.data_we)     data_q     <= upd.data_ptr;
      if (upd_hit && upd.buf_we)      buf_q      <= upd.buf_ptr;
    end
  end

  always_comb begin
    unique case (reg_idx)
      RI_DATA_PTR: rd_data = data_q;
      RI_BUF_PTR:  rd_data = buf_q;
      RI_GROUP:    rd_data = group_q;
      RI_CTX_PTR:  rd_data = ctx_q;
      RI_CMD:      rd_data = cmd_q;
      RI_CFG:      rd_data = 32'(cfg_q);
      RI_STATUS:   rd_data = status_word(state_q, ch_eol_q, err_q);
      RI_MASK:     rd_data = 32'(mask_q);
      RI_RAW:      rd_data = 32'(raw_q);
      RI_MASKED:   rd_data = 32'(raw_q & mask_q);
      RI_STREAM:   rd_data = strm_q;
      default:     rd_data = '0;
    endcase
  end

  assign data_ptr = data_q;
  assign ctx_ptr  = ctx_q;
  assign state    = state_q;
  assign ch_eol   = ch_eol_q;
  assign desc_eol = desc_eol_q;
  assign cfg_en   = cfg_q[0];
  assign cfg_stop = cfg_q[1];
  assign irq      = |(raw_q & mask_q);

  assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1);

  assert_cfg_reset_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wdata[0]) |=> (state_q == ST_RESET));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !evt_hit) |=> ((raw_q & $past(wdata[IRQ_W-1:0])) == '0));

  assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && upd.start && !cfg_wr && !(evt_hit && evt_eol))
      |=> (state_q == ST_RUNNING && !ch_eol_q));

endmodule

// File: rtl/dcf_seq.sv
module dcf_seq #(
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_stream,
  input  logic              go_cont,
  input  logic [CH_W-1:0]   go_ch,
  input  logic [9:0]        go_bits,
  output logic              busy,
  output logic [CH_W-1:0]   seq_ch,
  input  logic [31:0]       sel_data_ptr,
  input  logic [31:0]       sel_ctx_ptr,
  input  logic              sel_ch_eol,
  input  logic              sel_client,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [CH_W-1:0]   cmd_ch,
  output logic [31:0]       cmd_addr,
  input  logic              rsp_valid,
  input  logic              rsp_eol,
  input  logic [31:0]       rsp_link,
  input  logic [31:0]       rsp_buf,
  output logic              upd_valid,
  output dcf_pkg::seq_upd_t upd
);
  import dcf_pkg::*;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_SD_ISS, SQ_SD_WAIT, SQ_SC_ISS, SQ_SC_WAIT,
    SQ_CR_ISS, SQ_CR_WAIT, SQ_CA_ISS, SQ_CA_WAIT, SQ_GO_ISS
  } seq_st_e;

  seq_st_e         st_q;
  logic [CH_W-1:0] ch_q;
  logic            burst_q, ctx_q;
  logic            advance;

  assign advance = !rsp_eol && sel_ch_eol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      ch_q    <= '0;
      burst_q <= 1'b0;
      ctx_q   <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (go_stream) begin
            ch_q    <= go_ch;
            burst_q <= |(go_bits & SC_BURST);
            ctx_q   <= |(go_bits & SC_LOAD_CTX);
            st_q    <= (|(go_bits & SC_LOAD_DATA)) ? SQ_SD_ISS : SQ_SC_ISS;
          end else if (go_cont) begin
            ch_q    <= go_ch;
            burst_q <= 1'b0;
            ctx_q   <= 1'b0;
            st_q    <= SQ_CR_ISS;
          end
        end
        SQ_SD_ISS: if (cmd_ready) st_q <= SQ_SD_WAIT;
        SQ_SC_ISS: if (cmd_ready) st_q <= SQ_SC_WAIT;
        SQ_CR_ISS: if (cmd_ready) st_q <= SQ_CR_WAIT;
        SQ_CA_ISS: if (cmd_ready) st_q <= SQ_CA_WAIT;
        SQ_GO_ISS: if (cmd_ready) st_q <= ctx_q ? SQ_SC_ISS : SQ_IDLE;
        SQ_SD_WAIT: if (rsp_valid)
          st_q <= (burst_q && sel_client) ? SQ_GO_ISS : (ctx_q ? SQ_SC_ISS : SQ_IDLE);
        SQ_SC_WAIT: if (rsp_valid) st_q <= SQ_IDLE;
        SQ_CR_WAIT: if (rsp_valid) st_q <= advance ? SQ_CA_ISS : SQ_IDLE;
        SQ_CA_WAIT: if (rsp_valid) st_q <= sel_client ? SQ_GO_ISS : SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_LOAD_DATA;
    cmd_addr  = sel_data_ptr;
    unique case (st_q)
      SQ_SD_ISS, SQ_CR_ISS, SQ_CA_ISS: cmd_valid = 1'b1;
      SQ_SC_ISS: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_LOAD_CTX;
        cmd_addr  = sel_ctx_ptr;
      end
      SQ_GO_ISS: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_START;
      end
      default: ;
    endcase
  end

  always_comb begin
    upd = '0;
    unique case (st_q)
      SQ_SD_WAIT: if (rsp_valid) begin
        upd.desc_eol_we = 1'b1;
        upd.desc_eol    = rsp_eol;
      end
      SQ_SC_WAIT: if (rsp_valid) begin
        upd.data_we  = 1'b1;
        upd.data_ptr = rsp_link;
        upd.buf_we   = 1'b1;
        upd.buf_ptr  = rsp_buf;
      end
      SQ_CR_WAIT: if (rsp_valid) begin
        upd.desc_eol_we = 1'b1;
        upd.desc_eol    = rsp_eol;
        if (advance) begin
          upd.data_we  = 1'b1;
          upd.data_ptr = rsp_link;
        end else begin
          upd.buf_we  = 1'b1;
          upd.buf_ptr = rsp_buf;
        end
      end
      SQ_CA_WAIT: if (rsp_valid) begin
        upd.desc_eol_we = 1'b1;
        upd.desc_eol    = rsp_eol;
        upd.buf_we      = 1'b1;
        upd.buf_ptr     = rsp_buf;
      end
      SQ_GO_ISS: upd.start = cmd_ready;
      default: ;
    endcase
  end

  assign upd_valid = upd.desc_eol_we | upd.data_we | upd.buf_we | upd.start;
  assign busy      = (st_q != SQ_IDLE);
  assign seq_ch    = ch_q;
  assign cmd_ch    = ch_q;

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_ch)));

  assert_start_has_client_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_START) |-> sel_client);

endmodule

// File: rtl/dma_ctl_front.sv
module dma_ctl_front #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int IRQ_W  = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CHF_W = ADDR_W - dcf_pkg::WIN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic [NUM_CH-1:0] client_present,
  input  logic              evt_valid,
  input  logic [CH_W-1:0]   evt_ch,
  input  logic [IRQ_W-1:0]  evt_irq,
  input  logic              evt_eol,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [CH_W-1:0]   cmd_ch,
  output logic [31:0]       cmd_addr,
  input  logic              rsp_valid,
  input  logic              rsp_eol,
  input  logic [31:0]       rsp_link,
  input  logic [31:0]       rsp_buf,
  output logic [NUM_CH-1:0] irq
);
  import dcf_pkg::*;

  logic [CHF_W-1:0] ch_idx;
  logic [5:0]       reg_idx;
  logic             word_ok, ch_ok;

  dcf_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
    .addr(bus_addr), .size(bus_size), .ch_idx(ch_idx),
    .reg_idx(reg_idx), .word_ok(word_ok), .ch_ok(ch_ok)
  );

  logic [31:0]  rd_arr   [NUM_CH];
  logic [31:0]  data_arr [NUM_CH];
  logic [31:0]  ctx_arr  [NUM_CH];
  chan_state_e  st_arr   [NUM_CH];
  logic [NUM_CH-1:0] eol_v, deol_v, en_v, stop_v, wr_v;

  logic            seq_busy, upd_valid;
  logic [CH_W-1:0] seq_ch;
  seq_upd_t        upd;
  logic            acc_ok, wr_fire, strm_go, cont_go, needs_seq, stall;

  // addressed-channel view for the continue gate and read data
  logic [31:0] addr_rd;
  logic        addr_cont_ok;
  always_comb begin
    addr_rd      = '0;
    addr_cont_ok = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CHF_W'(i)) begin
        addr_rd      = rd_arr[i];
        addr_cont_ok = en_v[i] && client_present[i] && !stop_v[i] &&
                       (st_arr[i] == ST_RUNNING) && deol_v[i];
      end
    end
  end

  assign acc_ok    = bus_req && word_ok && ch_ok;
  assign strm_go   = (reg_idx == RI_STREAM) && stream_needs_engine(bus_wdata);
  assign cont_go   = (reg_idx == RI_CMD) && addr_cont_ok;
  assign needs_seq = acc_ok && bus_we && (strm_go || cont_go);
  assign stall     = needs_seq && seq_busy;
  assign bus_ack   = bus_req && !stall;
  assign bus_err   = bus_req && !(word_ok && ch_ok);
  assign bus_rdata = (acc_ok && !bus_we) ? addr_rd : 32'd0;
  assign wr_fire   = acc_ok && bus_we && !stall;

  // sequencer-side channel selection
  logic [31:0] sel_data, sel_ctx;
  logic        sel_eol, sel_client;
  always_comb begin
    sel_data   = '0;
    sel_ctx    = '0;
    sel_eol    = 1'b0;
    sel_client = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (seq_ch == CH_W'(i)) begin
        sel_data   = data_arr[i];
        sel_ctx    = ctx_arr[i];
        sel_eol    = eol_v[i];
        sel_client = client_present[i];
      end
    end
  end

  dcf_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_stream(wr_fire && strm_go), .go_cont(wr_fire && cont_go),
    .go_ch(CH_W'(ch_idx)), .go_bits(bus_wdata[9:0]),
    .busy(seq_busy), .seq_ch(seq_ch),
    .sel_data_ptr(sel_data), .sel_ctx_ptr(sel_ctx),
    .sel_ch_eol(sel_eol), .sel_client(sel_client),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_eol(rsp_eol), .rsp_link(rsp_link), .rsp_buf(rsp_buf),
    .upd_valid(upd_valid), .upd(upd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign wr_v[g] = wr_fire && (ch_idx == CHF_W'(g));
    dcf_chan #(.IRQ_W(IRQ_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_v[g]), .reg_idx(reg_idx), .wdata(bus_wdata),
      .evt_hit(evt_valid && evt_ch == CH_W'(g)), .evt_irq(evt_irq), .evt_eol(evt_eol),
      .upd_hit(upd_valid && seq_ch == CH_W'(g)), .upd(upd),
      .rd_data(rd_arr[g]), .data_ptr(data_arr[g]), .ctx_ptr(ctx_arr[g]),
      .state(st_arr[g]), .ch_eol(eol_v[g]), .desc_eol(deol_v[g]),
      .cfg_en(en_v[g]), .cfg_stop(stop_v[g]), .irq(irq[g])
    );
  end

  assert_subword_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size != SIZE_WORD) |-> (bus_err && bus_ack && bus_rdata == 32'd0));

  assert_no_write_on_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (wr_v == '0));

endmodule

// File: tb/dma_ctl_front_tb_top.sv
module dma_ctl_front_tb_top;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 16;
  localparam int IRQ_W  = 4;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              bus_req = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0]        bus_size = 2'd2;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic              bus_ack, bus_err;
  logic [NUM_CH-1:0] client_present = 3'b011;
  logic              evt_valid = 0, evt_eol = 0;
  logic [CH_W-1:0]   evt_ch = '0;
  logic [IRQ_W-1:0]  evt_irq = '0;
  logic              cmd_valid, cmd_ready = 1'b1;
  logic [1:0]        cmd_op;
  logic [CH_W-1:0]   cmd_ch;
  logic [31:0]       cmd_addr;
  logic              rsp_valid = 0, rsp_eol = 0;
  logic [31:0]       rsp_link = '0, rsp_buf = '0;
  logic [NUM_CH-1:0] irq;

  dma_ctl_front #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [35:0] expq [$];
  logic [64:0] rspq [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ra(int ch, int off);
    return 16'((ch << 13) | off);
  endfunction

  task automatic xfer(logic we, logic [15:0] a, logic [1:0] sz, logic [31:0] wd,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    #1;
    while (!bus_ack) begin @(negedge clk); #1; end
    rd = bus_rdata; er = bus_err;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wr(int ch, int off, logic [31:0] v);
    logic [31:0] d; logic e;
    xfer(1'b1, ra(ch, off), 2'd2, v, d, e);
  endtask

  task automatic rd_chk(string tag, int ch, int off, logic [31:0] exp);
    logic [31:0] d; logic e;
    xfer(1'b0, ra(ch, off), 2'd2, 32'd0, d, e);
    chk(tag, d, exp);
  endtask

  task automatic expect_cmd(int op, int ch, logic [31:0] a);
    expq.push_back({2'(op), 2'(ch), a});
  endtask

  task automatic settle(string tag);
    repeat (12) @(posedge clk);
    chk(tag, 32'(expq.size()), 32'd0);
  endtask

  task automatic event_pulse(int ch, logic [3:0] bits, logic eol);
    @(negedge clk);
    evt_valid = 1; evt_ch = CH_W'(ch); evt_irq = bits; evt_eol = eol;
    @(negedge clk);
    evt_valid = 0; evt_irq = '0; evt_eol = 0;
  endtask

  // engine model: scores commands against the expected queue, answers loads
  initial begin
    int pend = 0;
    logic [35:0] e;
    logic [64:0] r;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          r = (rspq.size() > 0) ? rspq.pop_front() : '0;
          {rsp_eol, rsp_link, rsp_buf} = r;
          rsp_valid = 1;
        end
      end
      if (cmd_valid && rst_n) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4/R8 unexpected command actual=0x%09h expected=none",
                   {cmd_op, cmd_ch, cmd_addr});
        end else begin
          e = expq.pop_front();
          chk("R4/R8 engine command", {4'(0), cmd_op, cmd_ch} , {4'(0), e[35:32]});
          chk("R4/R8 command address", cmd_addr, e[31:0]);
        end
        if (cmd_op != 2'd2) pend = 2;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R2 reset status and quiet interrupt
    rd_chk("R2 reset status", 0, 'h88, 32'h101);
    chk("R6 irq after reset", 32'(irq), 32'd0);

    // R1 pointer round trips
    wr(0, 'h58, 32'h1000); wr(0, 'h60, 32'hABCD0000); wr(1, 'h7C, 32'h5000);
    rd_chk("R1 descriptor pointer", 0, 'h58, 32'h1000);
    rd_chk("R1 group pointer", 0, 'h60, 32'hABCD0000);
    rd_chk("R1 context pointer", 1, 'h7C, 32'h5000);

    // R3 config state forcing
    wr(0, 'h84, 32'h3); rd_chk("R3 stop bit", 0, 'h88, 32'h102);
    wr(0, 'h84, 32'h2); rd_chk("R3 reset wins", 0, 'h88, 32'h101);
    wr(0, 'h84, 32'h1); rd_chk("R3 enable keeps reset", 0, 'h88, 32'h101);

    // R4 load data + burst start
    expect_cmd(0, 0, 32'h1000); expect_cmd(2, 0, 32'h1000);
    rspq.push_back({1'b0, 32'h0, 32'h0});
    wr(0, 'h9C, 32'h160);
    settle("R4 load and burst");
    rd_chk("R4 running after burst", 0, 'h88, 32'h104);

    // R7 continue ignored: descriptor not at end of list
    wr(0, 'h80, 32'h1);
    settle("R7 continue ignored");

    // R11 end-of-list event
    event_pulse(0, 4'h0, 1'b1);
    rd_chk("R11 eol status", 0, 'h88, 32'h124);

    // R8 continue with descriptor still at end of list: reload only
    expect_cmd(0, 0, 32'h1000);
    rspq.push_back({1'b1, 32'h0, 32'h2222});
    wr(0, 'h80, 32'h1);
    settle("R8 reload only");
    rd_chk("R8 buffer from reload", 0, 'h5C, 32'h2222);
    rd_chk("R8 still parked", 0, 'h88, 32'h124);

    // R8 continue with cleared flag: advance and restart
    expect_cmd(0, 0, 32'h1000); expect_cmd(0, 0, 32'h3000); expect_cmd(2, 0, 32'h3000);
    rspq.push_back({1'b0, 32'h3000, 32'h3100});
    rspq.push_back({1'b1, 32'h0, 32'h3300});
    wr(0, 'h80, 32'h1);
    settle("R8 advance sequence");
    rd_chk("R8 advanced pointer", 0, 'h58, 32'h3000);
    rd_chk("R8 advanced buffer", 0, 'h5C, 32'h3300);
    rd_chk("R8 restarted", 0, 'h88, 32'h104);

    // R7 stopped channel ignores continue
    wr(0, 'h84, 32'h3);
    wr(0, 'h80, 32'h1);
    settle("R7 stopped ignores continue");

    // R5 context load, and R4 order data then context
    wr(1, 'h84, 32'h1); wr(1, 'h58, 32'h4000);
    expect_cmd(0, 1, 32'h4000); expect_cmd(1, 1, 32'h5000);
    rspq.push_back({1'b0, 32'h0, 32'h0});
    rspq.push_back({1'b0, 32'h6000, 32'h6100});
    wr(1, 'h9C, 32'h340);
    settle("R4 data then context order");
    rd_chk("R5 pointer from context", 1, 'h58, 32'h6000);
    rd_chk("R5 buffer from context", 1, 'h5C, 32'h6100);

    // R4 burst withheld with no client on channel 2
    wr(2, 'h84, 32'h1);
    expect_cmd(0, 2, 32'h0);
    wr(2, 'h9C, 32'h160);
    settle("R4 no start without client");
    rd_chk("R4 no-client state", 2, 'h88, 32'h101);

    // R6 interrupts on channel 1
    event_pulse(1, 4'h5, 1'b0);
    rd_chk("R6 raw", 1, 'h94, 32'h5);
    chk("R6 irq masked off", 32'(irq[1]), 32'd0);
    wr(1, 'h8C, 32'h4);
    chk("R6 irq after mask write", 32'(irq[1]), 32'd1);
    rd_chk("R6 masked", 1, 'h98, 32'h4);
    wr(1, 'h90, 32'h4);
    chk("R6 irq after ack", 32'(irq[1]), 32'd0);
    rd_chk("R6 raw after ack", 1, 'h94, 32'h1);
    rd_chk("R6 ack reads zero", 1, 'h90, 32'h0);

    // R9 stray bits stored and flagged
    wr(1, 'h80, 32'h3);
    rd_chk("R9 command stored", 1, 'h80, 32'h3);
    rd_chk("R9 error flag", 1, 'h88, 32'h301);
    wr(2, 'h9C, 32'h400);
    settle("R9 stray stream bits issue nothing");
    rd_chk("R9 stream stored", 2, 'h9C, 32'h400);
    rd_chk("R9 stream error flag", 2, 'h88, 32'h301);

    // R10 sub-word access
    xfer(1'b1, ra(0, 'h60), 2'd0, 32'h12345678, d, e);
    chk("R10 byte write error", 32'(e), 32'd1);
    xfer(1'b0, ra(0, 'h60), 2'd1, 32'd0, d, e);
    chk("R10 halfword read error", 32'(e), 32'd1);
    chk("R10 halfword read data", d, 32'd0);
    rd_chk("R10 register untouched", 0, 'h60, 32'hABCD0000);

    // R1 out-of-range channel
    xfer(1'b0, ra(3, 'h88), 2'd2, 32'd0, d, e);
    chk("R1 missing channel error", 32'(e), 32'd1);
    chk("R1 missing channel data", d, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule